// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Receiver

The block samples a demodulated infrared line and measures every symbol as a pair of widths. The first width is the mark, when the line sits at its active level. The second is the space, the idle gap that follows. Both widths are counted in time units: a programmable prescaler turns the system clock into a 1 µs tick, and a fixed divider (`UNIT_US`, 10 by default) turns that tick into a unit. Each finished pair goes into a receive FIFO as one 32-bit word.

A frame ends when the mark plus the running space reaches a programmed maximum width. The symbol is then stored with the space clipped at that limit, a timeout event is raised, and the block waits for the next mark.

Software drives the block over a simple 32-bit register bus with byte offsets. Enable is at 0x00, configuration at 0x04, busy at 0x1C, count at 0x20, data/pop at 0x24, mask at 0x28, status at 0x2C, clear at 0x30 and start at 0x34. Reads are combinational from `bus_addr`. A write takes effect at the clock edge where `bus_wr` is high. A read of the data register with `bus_rd` high pops the FIFO at that edge.

Top module: `ir_symbol_rx`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is low.
- R2: A write to the enable register that turns the block on makes the busy register (0x1C) read 1 for `SETTLE_CYC` cycles. It then reads 0. No symbol is captured while busy is 1.
- R3: The configuration word is laid out as follows: max width in bits [31:16], format in [15:14], FIFO level minus one in [13:8], raw enable in bit 7, prescaler in [6:0]. A unit lasts (prescaler+1)·`UNIT_US` clocks. A symbol word holds the mark width in units in bits [15:0] and the space width in units in bits [31:16]. The word is pushed when the next mark begins.
- R4: Format 0 treats the line low as the mark. Format 1 treats the line high as the mark.
- R5: When mark+space reaches the max width, the block pushes a word whose space field is max width minus mark. It sets the timeout event and then waits for a new mark.
- R6: The count register returns the FIFO occupancy. A data read returns the oldest word and pops it. A data read from an empty FIFO returns 0 and changes nothing.
- R7: The receive event is set by a push that brings the occupancy to level field + 1 or more.
- R8: A push while the FIFO is full drops the new word and sets the overflow event. The stored words stay intact.
- R9: The status register shows the receive event at bits 8 and 24, timeout at bits 9 and 25, and overflow at bits 10 and 26. Events are sticky. Writing the clear register with bit 16, 17 or 18 clears receive, timeout or overflow respectively.
- R10: `irq` is the OR of all events whose mask bit is 0. Mask bit 0 blocks receive, bit 1 blocks timeout, bit 2 blocks overflow.
- R11: With `NEED_EXTRA_EN`=1, the block is enabled only when enable bits 0 and 8 are both set.
- R12: Capture runs only when all of these hold: the block is enabled, it is not busy, a start write has armed it, and the raw bit is 1. Disabling the block disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, which pops on the data offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives frames with mixed mark and space lengths, so a swapped field or an off-by-one unit count shows up in a popped word. It repeats the capture with inverted polarity, which tells the two formats apart. A burst longer than the FIFO exercises drop-on-full against the kept words. Frames sent while the block is disabled, unarmed, busy or in non-raw mode must leave the count at zero.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;

    localparam logic [7:0] OFS_ENABLE = 8'h00;
    localparam logic [7:0] OFS_CONFIG = 8'h04;
    localparam logic [7:0] OFS_BUSY   = 8'h1C;
    localparam logic [7:0] OFS_COUNT  = 8'h20;
    localparam logic [7:0] OFS_DATA   = 8'h24;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_STATUS = 8'h2C;
    localparam logic [7:0] OFS_CLEAR  = 8'h30;
    localparam logic [7:0] OFS_START  = 8'h34;

    localparam int unsigned EV_RX  = 0;
    localparam int unsigned EV_TMO = 1;
    localparam int unsigned EV_OVF = 2;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_MARK  = 2'd1,
        CAP_SPACE = 2'd2
    } cap_state_e;

    // packed so that the field positions match the configuration register
    typedef struct packed {
        logic [15:0] max_w;
        logic [1:0]  fmt;
        logic [5:0]  lvl;
        logic        raw;
        logic [6:0]  pre;
    } cfg_t;

endpackage

// File: rtl/ir_rx_sync.sv
module ir_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl_o,
    output logic lvl_prev_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl_o      = sync_q.s2;
    assign lvl_prev_o = sync_q.s3;

endmodule

// File: rtl/ir_rx_meas.sv
module ir_rx_meas
    import ir_rx_pkg::*;
#(
    parameter int unsigned UNIT_US = 10,
    parameter int unsigned W_W     = 16,
    parameter int unsigned PRE_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             inv,
    input  logic [PRE_W-1:0] pre,
    input  logic [W_W-1:0]   max_w,
    input  logic             lvl,
    input  logic             lvl_prev,
    output logic             push_o,
    output logic [2*W_W-1:0] word_o,
    output logic             tmo_o,
    output cap_state_e       state_o
);
    localparam int unsigned UNIT_CW = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;
    localparam logic [W_W-1:0] W_SAT = '1;
    localparam logic [UNIT_CW-1:0] UNIT_LAST = UNIT_CW'(UNIT_US - 1);

    typedef struct packed {
        cap_state_e         st;
        logic [PRE_W-1:0]   pre_cnt;
        logic [UNIT_CW-1:0] unit_cnt;
        logic [W_W-1:0]     width;
        logic [W_W-1:0]     mark;
    } meas_t;

    meas_t meas_d, meas_q;

    logic           mark_now, mark_was, mark_rise, mark_fall;
    logic           us_tick, unit_tick;
    logic [W_W-1:0] width_inc;
    logic [W_W:0]   sum_w;

    always_comb begin
        mark_now  = inv ? lvl : ~lvl;
        mark_was  = inv ? lvl_prev : ~lvl_prev;
        mark_rise = mark_now & ~mark_was;
        mark_fall = ~mark_now & mark_was;
        us_tick   = (meas_q.pre_cnt == pre);
        unit_tick = us_tick && (meas_q.unit_cnt == UNIT_LAST);
        width_inc = (meas_q.width == W_SAT) ? meas_q.width : meas_q.width + 1'b1;
        sum_w     = {1'b0, meas_q.mark} + {1'b0, meas_q.width};

        meas_d = meas_q;
        push_o = 1'b0;
        tmo_o  = 1'b0;
        word_o = {meas_q.width, meas_q.mark};

        // unit timer restarts on every line edge so that widths are edge-aligned
        if (mark_rise || mark_fall || !run) begin
            meas_d.pre_cnt  = '0;
            meas_d.unit_cnt = '0;
        end else if (us_tick) begin
            meas_d.pre_cnt  = '0;
            meas_d.unit_cnt = unit_tick ? '0 : meas_q.unit_cnt + 1'b1;
        end else begin
            meas_d.pre_cnt  = meas_q.pre_cnt + 1'b1;
        end

        if (!run) begin
            meas_d.st    = CAP_IDLE;
            meas_d.width = '0;
        end else begin
            unique case (meas_q.st)
                CAP_IDLE: begin
                    if (mark_rise) begin
                        meas_d.st    = CAP_MARK;
                        meas_d.width = '0;
                    end
                end
                CAP_MARK: begin
                    if (mark_fall) begin
                        meas_d.st    = CAP_SPACE;
                        meas_d.mark  = meas_q.width;
                        meas_d.width = '0;
                    end else if (unit_tick) begin
                        meas_d.width = width_inc;
                    end
                end
                CAP_SPACE: begin
                    if (mark_rise) begin
                        push_o       = 1'b1;
                        meas_d.st    = CAP_MARK;
                        meas_d.width = '0;
                    end else if (sum_w >= {1'b0, max_w}) begin
                        push_o       = 1'b1;
                        tmo_o        = 1'b1;
                        meas_d.st    = CAP_IDLE;
                        meas_d.width = '0;
                    end else if (unit_tick) begin
                        meas_d.width = width_inc;
                    end
                end
                default: meas_d.st = CAP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meas_q <= '{st: CAP_IDLE, default: '0};
        else        meas_q <= meas_d;
    end

    assign state_o = meas_q.st;

endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic [DW-1:0] mem [DEPTH];
    logic acc, take;

    always_comb begin
        full   = (fifo_q.cnt == CNT_FULL);
        empty  = (fifo_q.cnt == '0);
        acc    = push && !full;
        take   = pop && !empty;
        fifo_d = fifo_q;
        if (acc)  fifo_d.wp = (fifo_q.wp == PTR_LAST) ? '0 : fifo_q.wp + 1'b1;
        if (take) fifo_d.rp = (fifo_q.rp == PTR_LAST) ? '0 : fifo_q.rp + 1'b1;
        fifo_d.cnt = fifo_q.cnt + CW'(acc) - CW'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (acc) mem[fifo_q.wp] <= wdata;
    end

    assign rdata = mem[fifo_q.rp];
    assign count = fifo_q.cnt;

    // R6: a pop with no accepted push lowers the occupancy by one
    a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !(push && !full)) |=> (fifo_q.cnt == $past(fifo_q.cnt) - 1'b1));

    // R8: a push into a full FIFO without a pop leaves the occupancy unchanged
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (fifo_q.cnt == CNT_FULL));

endmodule

// File: rtl/ir_symbol_rx.sv
module ir_symbol_rx
    import ir_rx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH    = 16,
    parameter int unsigned UNIT_US       = 10,
    parameter int unsigned SETTLE_CYC    = 8,
    parameter bit          NEED_EXTRA_EN = 1'b1,
    parameter int unsigned ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam int unsigned CW     = $clog2(FIFO_DEPTH + 1);
    localparam int unsigned BUSY_W = $clog2(SETTLE_CYC + 1);
    localparam int unsigned W_W    = 16;

    typedef struct packed {
        logic              en_main;
        logic              en_aux;
        cfg_t              cfg;
        logic [2:0]        mask;
        logic [2:0]        st;
        logic              armed;
        logic [BUSY_W-1:0] busy_cnt;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             lvl, lvl_prev;
    logic             m_push, m_tmo;
    logic [2*W_W-1:0] m_word;
    cap_state_e       cap_state;
    logic             f_pop, f_full, f_empty;
    logic [31:0]      f_rdata;
    logic [CW-1:0]    f_cnt, cnt_after;

    logic en_ok, new_en_ok, busy, run, acc;
    logic wr_en, wr_cfg, wr_mask, wr_clr, wr_start;
    logic [2:0] ev_set, ev_clr;

    // enable variant: one or two enable bits
    generate
        if (NEED_EXTRA_EN) begin : g_two_bit_en
            assign en_ok     = regs_q.en_main & regs_q.en_aux;
            assign new_en_ok = bus_wdata[0] & bus_wdata[8];
        end else begin : g_one_bit_en
            assign en_ok     = regs_q.en_main;
            assign new_en_ok = bus_wdata[0];
        end
    endgenerate

    assign busy = (regs_q.busy_cnt != '0);
    assign run  = en_ok && !busy && regs_q.armed && regs_q.cfg.raw;

    ir_rx_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (ir_in),
        .lvl_o      (lvl),
        .lvl_prev_o (lvl_prev)
    );

    ir_rx_meas #(
        .UNIT_US (UNIT_US),
        .W_W     (W_W),
        .PRE_W   (7)
    ) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .inv      (regs_q.cfg.fmt == 2'd1),
        .pre      (regs_q.cfg.pre),
        .max_w    (regs_q.cfg.max_w),
        .lvl      (lvl),
        .lvl_prev (lvl_prev),
        .push_o   (m_push),
        .word_o   (m_word),
        .tmo_o    (m_tmo),
        .state_o  (cap_state)
    );

    ir_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .DW    (32)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (m_push),
        .wdata (m_word),
        .pop   (f_pop),
        .rdata (f_rdata),
        .count (f_cnt),
        .full  (f_full),
        .empty (f_empty)
    );

    always_comb begin
        wr_en    = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));
        wr_cfg   = bus_wr && (bus_addr == ADDR_W'(OFS_CONFIG));
        wr_mask  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
        wr_clr   = bus_wr && (bus_addr == ADDR_W'(OFS_CLEAR));
        wr_start = bus_wr && (bus_addr == ADDR_W'(OFS_START));
        f_pop    = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));

        acc       = m_push && !f_full;
        cnt_after = f_cnt + CW'(acc) - CW'(f_pop && !f_empty);

        ev_set[EV_RX]  = acc && (32'(cnt_after) >= 32'(regs_q.cfg.lvl) + 32'd1);
        ev_set[EV_TMO] = m_push && m_tmo;
        ev_set[EV_OVF] = m_push && f_full;
        ev_clr         = wr_clr ? bus_wdata[18:16] : 3'b000;

        regs_d    = regs_q;
        regs_d.st = ev_set | (regs_q.st & ~ev_clr);

        if (wr_en) begin
            regs_d.en_main = bus_wdata[0];
            regs_d.en_aux  = bus_wdata[8];
        end
        if (wr_cfg)  regs_d.cfg  = cfg_t'(bus_wdata);
        if (wr_mask) regs_d.mask = bus_wdata[2:0];

        if (wr_en && new_en_ok && !en_ok)
            regs_d.busy_cnt = BUSY_W'(SETTLE_CYC);
        else if (wr_en && !new_en_ok)
            regs_d.busy_cnt = '0;
        else if (busy)
            regs_d.busy_cnt = regs_q.busy_cnt - 1'b1;

        regs_d.armed = wr_start || (regs_q.armed && en_ok);
        if (wr_en && !new_en_ok) regs_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_ENABLE): bus_rdata = {23'd0, regs_q.en_aux, 7'd0, regs_q.en_main};
            ADDR_W'(OFS_CONFIG): bus_rdata = 32'(regs_q.cfg);
            ADDR_W'(OFS_BUSY):   bus_rdata = {31'd0, busy};
            ADDR_W'(OFS_COUNT):  bus_rdata = 32'(f_cnt);
            ADDR_W'(OFS_DATA):   bus_rdata = f_empty ? 32'd0 : f_rdata;
            ADDR_W'(OFS_MASK):   bus_rdata = {29'd0, regs_q.mask};
            ADDR_W'(OFS_STATUS): bus_rdata = {5'd0, regs_q.st, 13'd0, regs_q.st, 8'd0};
            default:             bus_rdata = '0;
        endcase
    end

    assign irq = |(regs_q.st & ~regs_q.mask);

    // R8: occupancy never passes the depth
    a_r8_fifo_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(f_cnt) <= FIFO_DEPTH);

    // R9: a timeout event holds until its clear bit is written
    a_r9_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st[EV_TMO] && !(wr_clr && bus_wdata[17])) |=> regs_q.st[EV_TMO]);

    // R2: no capture activity while settling
    a_r2_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cap_state == CAP_IDLE));

    // R5: a timeout push returns the capture to waiting for a mark
    a_r5_tmo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (m_push && m_tmo) |=> (cap_state == CAP_IDLE));

endmodule

// File: tb/ir_symbol_rx_tb.sv
module ir_symbol_rx_tb;
    localparam int U = 10;  // clocks per unit with prescaler 0

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] expq[$];
    logic [31:0] v;

    always #10 clk = ~clk;  // 50 MHz

    ir_symbol_rx #(.FIFO_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic phase(input logic level, input int units);
        ir_in = level;
        repeat (units * U + U / 2) @(negedge clk);
    endtask

    task automatic settle(input logic level, input int cyc);
        ir_in = level;
        repeat (cyc) @(negedge clk);
    endtask

    function automatic logic [31:0] sym(input int space, input int mark);
        return {16'(space), 16'(mark)};
    endfunction

    task automatic drain(input string req);
        logic [31:0] d;
        rd(8'h20, d);
        check({req, " count"}, d, 32'(expq.size()));
        while (expq.size() > 0) begin
            rd(8'h24, d);
            check({req, " word"}, d, expq.pop_front());
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h2C, v); check("R1 status", v, 0);
        rd(8'h20, v); check("R1 count", v, 0);
        rd(8'h24, v); check("R1 data", v, 0);
        rd(8'h1C, v); check("R1 busy", v, 0);
        rd(8'h00, v); check("R1 enable", v, 0);
        check("R1 irq", 32'(irq), 0);

        // config: max 20, fmt 0, level field 1, raw, prescaler 0
        wr(8'h04, 32'h0014_0180);
        rd(8'h04, v); check("R3 config readback", v, 32'h0014_0180);

        // R11 main bit alone does not enable
        wr(8'h00, 32'h1);
        wr(8'h34, 32'h1);
        phase(1'b0, 2); phase(1'b1, 3); settle(1'b1, 300);
        rd(8'h20, v); check("R11 single enable bit", v, 0);

        // R2 settle window
        wr(8'h00, 32'h101);
        rd(8'h1C, v); check("R2 busy after enable", v, 1);
        repeat (10) @(negedge clk);
        rd(8'h1C, v); check("R2 busy done", v, 0);

        // R12 not armed: nothing captured
        phase(1'b0, 2); phase(1'b1, 2); settle(1'b1, 300);
        rd(8'h20, v); check("R12 unarmed", v, 0);

        // R3 R5 R7 main frame
        wr(8'h34, 32'h0);
        phase(1'b0, 2); phase(1'b1, 3);
        ir_in = 1'b0;
        repeat (20) @(negedge clk);
        rd(8'h2C, v); check("R7 below level", v, 0);
        repeat (4 * U + U / 2 - 22) @(negedge clk);
        phase(1'b1, 1); phase(1'b0, 3); settle(1'b1, 300);
        expq.push_back(sym(3, 2));
        expq.push_back(sym(1, 4));
        expq.push_back(sym(17, 3));
        rd(8'h2C, v); check("R7 R9 rx and timeout bits", v, 32'h0300_0300);
        check("R10 irq unmasked", 32'(irq), 1);
        drain("R3 R5");
        rd(8'h24, v); check("R6 empty read", v, 0);
        rd(8'h20, v); check("R6 empty count", v, 0);

        // R10 masking
        wr(8'h28, 32'h3); @(negedge clk);
        check("R10 irq masked", 32'(irq), 0);
        wr(8'h28, 32'h1); @(negedge clk);
        check("R10 timeout unmasked", 32'(irq), 1);

        // R9 one-hot clears
        wr(8'h30, 32'h0001_0000);
        rd(8'h2C, v); check("R9 clear rx", v, 32'h0200_0200);
        wr(8'h30, 32'h0002_0000);
        rd(8'h2C, v); check("R9 clear timeout", v, 0);
        check("R9 irq after clear", 32'(irq), 0);
        wr(8'h28, 32'h0);

        // R4 inverted polarity
        wr(8'h04, 32'h0014_4180);
        settle(1'b0, 30);
        phase(1'b1, 5); phase(1'b0, 2); phase(1'b1, 1); settle(1'b0, 300);
        expq.push_back(sym(2, 5));
        expq.push_back(sym(19, 1));
        drain("R4");
        wr(8'h30, 32'h0007_0000);

        // R8 overflow with depth 4
        wr(8'h04, 32'h0014_0180);
        settle(1'b1, 30);
        for (int i = 0; i < 5; i++) begin
            phase(1'b0, 1); phase(1'b1, 1);
        end
        phase(1'b0, 2); settle(1'b1, 300);
        for (int i = 0; i < 4; i++) expq.push_back(sym(1, 1));
        rd(8'h2C, v); check("R8 overflow status", v, 32'h0700_0700);
        drain("R8");
        wr(8'h30, 32'h0007_0000);
        rd(8'h2C, v); check("R9 clear all", v, 0);

        // R12 raw bit off
        wr(8'h04, 32'h0014_0100);
        phase(1'b0, 2); phase(1'b1, 2); settle(1'b1, 300);
        rd(8'h20, v); check("R12 raw off", v, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule